// File: doc/BRIEF.md
# Paged Transfer Sequencing Controller

This block sequences the movement of test data, one page at a time, between two external memory banks and the tester paths. A read machine fetches a page of 32-bit words from memory bank A and pushes them into the input tester FIFO. A write machine drains captured results from the output tester FIFO into memory bank B. A third machine paces the device-under-test stream: it steps one vector per cycle from the input FIFO to the output FIFO while both sides allow it. Memories and FIFOs are seen as plain request/acknowledge and full/empty ports, and the block passes data through without buffering it.

Both page machines share one pattern. An idle machine starts on a start strobe. It waits in a page check until the page-available input is high. It then opens the page by clearing the word address and arming the delay counter. It spends `START_DLY` cycles in a start delay and one cycle in an init state that loads the word counter with `PAGE_WORDS`. The burst follows: it requests one word per cycle, counts accepted words down to zero, and then enters a finish state. Leaving the finish state raises a one-cycle page-done pulse.

The read machine has two extra states. After finish it goes to a what-next state. If the loop enable is high it passes through a loop state back to the page check and reads the same page again from address 0. Otherwise it returns to idle. The write machine has no loop and returns to idle straight from finish. The DUT machine has three states: idle, send and hold. It moves from idle to send when run goes high. It moves from send to hold when the input FIFO is empty or the output FIFO is full, and from hold back to send when both conditions have cleared. From any state it returns to idle when run goes low.

Top module: `page_xfer_ctrl`

## Requirements
- R1: The read machine stays idle until `rd_start` is sampled high. It then waits in the page check, with `rda_req` low, for as long as `rd_page_avail` is low.
- R2: After `rd_page_avail` is sampled high in the page check, the first `rda_req` appears in the (`START_DLY`+3)-th cycle: one open cycle, `START_DLY` delay cycles, one init cycle, then the burst.
- R3: A read burst accepts exactly `PAGE_WORDS` words, where a word is accepted in a cycle with `rda_req` and `rda_ack` both high. The word address `rda_addr` starts at 0 and rises by one per accepted word. `fin_push` is high exactly on accepted words, with `fin_data` equal to `rda_data`.
- R4: `rda_req` is never high while `fin_full` is high.
- R5: `rd_page_done` is high for exactly one cycle per page read, in the cycle after the read finish state.
- R6: In the what-next state, a high `rd_loop_en` sends the machine back to the page check, and the page is read again from address 0. A low `rd_loop_en` returns it to idle, and no further requests are made.
- R7: The write machine follows the same sequence on `wr_start` and `wr_page_avail`. Its first `wbb_req` comes in the (`START_DLY`+3)-th cycle. It accepts `PAGE_WORDS` words on `wbb_req` and `wbb_ack` at addresses from 0 upward, with `wbb_data` equal to `fout_data`. `fout_pop` is high exactly on accepted words, and `wbb_req` is never high while `fout_empty` is high.
- R8: `wr_page_done` pulses for one cycle after the write finish state, and the write machine then rests in idle without further requests.
- R9: While `run` is high, `dut_step` is high in every cycle of the send state in which `fin_empty` and `fout_full` are both low. A blocking condition moves the machine to hold (`dut_hold` high, `dut_step` low) in the next cycle, and clearing it returns the machine to send in the next cycle.
- R10: `run` low returns the DUT machine to idle in the next cycle, with `dut_step` and `dut_hold` both low.
- R11: After reset all three machines are idle, and `rda_req`, `wbb_req`, `fin_push`, `fout_pop`, `dut_step`, `dut_hold` and both done pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_start | input | 1 | Start strobe for the read machine |
| rd_loop_en | input | 1 | Loop request sampled in the read what-next state |
| rd_page_avail | input | 1 | Page in bank A ready to read |
| rd_page_done | output | 1 | One-cycle pulse when a page read finishes |
| rda_req | output | 1 | Word read request to bank A |
| rda_ack | input | 1 | Bank A accepts the request and returns data |
| rda_addr | output | ADDR_W | Word address in the bank A page |
| rda_data | input | DATA_W | Read data from bank A |
| fin_full | input | 1 | Input tester FIFO is full |
| fin_push | output | 1 | Push into the input tester FIFO |
| fin_data | output | DATA_W | Data pushed into the input tester FIFO |
| run | input | 1 | Run / hold-off control for the DUT stream |
| fin_empty | input | 1 | Input tester FIFO is empty |
| fout_full | input | 1 | Output tester FIFO is full |
| dut_step | output | 1 | Advance one vector through the device |
| dut_hold | output | 1 | DUT stream is in the hold state |
| wr_start | input | 1 | Start strobe for the write machine |
| wr_page_avail | input | 1 | Page in bank B free to write |
| wr_page_done | output | 1 | One-cycle pulse when a page write finishes |
| fout_empty | input | 1 | Output tester FIFO is empty |
| fout_data | input | DATA_W | Head word of the output tester FIFO |
| fout_pop | output | 1 | Pop from the output tester FIFO |
| wbb_req | output | 1 | Word write request to bank B |
| wbb_ack | input | 1 | Bank B accepts the write |
| wbb_addr | output | ADDR_W | Word address in the bank B page |
| wbb_data | output | DATA_W | Write data to bank B |

## Verification
The hardest case to reach from the ports is the what-next decision. It is made in the cycle in which `rd_page_done` is visible, so the loop enable has to be set before the first page ends and dropped within the next cycle, if the second pass is to end in idle rather than loop again. The stimulus holds `rd_loop_en` high from the start, drops it just after the first done pulse is seen, and expects two full pages at addresses 0 through `PAGE_WORDS`-1 followed by silence. This happens while acknowledge and FIFO-full patterns keep stalling the bursts.

// File: rtl/page_xfer_pkg.sv
package page_xfer_pkg;

    typedef enum logic [3:0] {
        RD_IDLE,
        RD_CHECK,
        RD_OPEN,
        RD_DELAY,
        RD_INIT,
        RD_BURST,
        RD_FINISH,
        RD_NEXT,
        RD_LOOP
    } rd_state_e;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_CHECK,
        WR_OPEN,
        WR_DELAY,
        WR_INIT,
        WR_BURST,
        WR_FINISH
    } wr_state_e;

    typedef enum logic [1:0] {
        DT_IDLE,
        DT_SEND,
        DT_HOLD
    } dut_state_e;

endpackage

// File: rtl/page_rd_fsm.sv
module page_rd_fsm
    import page_xfer_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_WORDS = 8,
    parameter int START_DLY  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              loop_en,
    input  logic              page_avail,
    input  logic              ack,
    input  logic              fifo_full,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam int CW = $clog2(PAGE_WORDS + 1);
    localparam int DW = $clog2(START_DLY + 1);

    rd_state_e         state, nxt;
    logic [CW-1:0]     wcnt;
    logic [DW-1:0]     dly;
    logic              accept;

    assign accept = req && ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:   if (start) nxt = RD_CHECK;
            RD_CHECK:  if (page_avail) nxt = RD_OPEN;
            RD_OPEN:   nxt = RD_DELAY;
            RD_DELAY:  if (dly == DW'(1)) nxt = RD_INIT;
            RD_INIT:   nxt = RD_BURST;
            RD_BURST:  if (accept && wcnt == CW'(1)) nxt = RD_FINISH;
            RD_FINISH: nxt = RD_NEXT;
            RD_NEXT:   nxt = loop_en ? RD_LOOP : RD_IDLE;
            RD_LOOP:   nxt = RD_CHECK;
            default:   nxt = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
            dly  <= '0;
            addr <= '0;
            done <= 1'b0;
        end else begin
            done <= (state == RD_FINISH);
            if (state == RD_OPEN) begin
                addr <= '0;
                dly  <= DW'(START_DLY);
            end
            if (state == RD_DELAY) dly <= dly - DW'(1);
            if (state == RD_INIT)  wcnt <= CW'(PAGE_WORDS);
            if (accept) begin
                wcnt <= wcnt - CW'(1);
                addr <= addr + ADDR_W'(1);
            end
        end
    end

    always_comb begin
        req = (state == RD_BURST) && !fifo_full;
    end

    p_idle_waits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_IDLE && !start) |=> state == RD_IDLE);
    p_check_waits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_CHECK && !page_avail) |=> (state == RD_CHECK && !req));
    p_delay_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_DELAY) |-> dly != '0);
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wcnt != CW'(1)) |=> addr == $past(addr) + ADDR_W'(1));
    p_last_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wcnt == CW'(1)) |=> state == RD_FINISH);
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_next_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_NEXT && !loop_en) |=> state == RD_IDLE);
endmodule

// File: rtl/page_wr_fsm.sv
module page_wr_fsm
    import page_xfer_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_WORDS = 8,
    parameter int START_DLY  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              page_avail,
    input  logic              ack,
    input  logic              fifo_empty,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam int CW = $clog2(PAGE_WORDS + 1);
    localparam int DW = $clog2(START_DLY + 1);

    wr_state_e         state, nxt;
    logic [CW-1:0]     wcnt;
    logic [DW-1:0]     dly;
    logic              accept;

    assign accept = req && ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WR_IDLE:   if (start) nxt = WR_CHECK;
            WR_CHECK:  if (page_avail) nxt = WR_OPEN;
            WR_OPEN:   nxt = WR_DELAY;
            WR_DELAY:  if (dly == DW'(1)) nxt = WR_INIT;
            WR_INIT:   nxt = WR_BURST;
            WR_BURST:  if (accept && wcnt == CW'(1)) nxt = WR_FINISH;
            WR_FINISH: nxt = WR_IDLE;
            default:   nxt = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
            dly  <= '0;
            addr <= '0;
            done <= 1'b0;
        end else begin
            done <= (state == WR_FINISH);
            if (state == WR_OPEN) begin
                addr <= '0;
                dly  <= DW'(START_DLY);
            end
            if (state == WR_DELAY) dly <= dly - DW'(1);
            if (state == WR_INIT)  wcnt <= CW'(PAGE_WORDS);
            if (accept) begin
                wcnt <= wcnt - CW'(1);
                addr <= addr + ADDR_W'(1);
            end
        end
    end

    always_comb begin
        req = (state == WR_BURST) && !fifo_empty;
    end

    p_wr_check_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_CHECK && !page_avail) |=> state == WR_CHECK);
    p_wr_last_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wcnt == CW'(1)) |=> state == WR_FINISH);
    p_wr_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == WR_IDLE && !req));
    p_wr_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/page_dut_fsm.sv
module page_dut_fsm
    import page_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic in_empty,
    input  logic out_full,
    output logic step,
    output logic hold
);
    dut_state_e state, nxt;
    logic       blocked;

    assign blocked = in_empty || out_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DT_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            DT_IDLE: if (run) nxt = DT_SEND;
            DT_SEND: if (!run) nxt = DT_IDLE;
                     else if (blocked) nxt = DT_HOLD;
            DT_HOLD: if (!run) nxt = DT_IDLE;
                     else if (!blocked) nxt = DT_SEND;
            default: nxt = DT_IDLE;
        endcase
    end

    always_comb begin
        step = (state == DT_SEND) && run && !blocked;
        hold = (state == DT_HOLD);
    end

    p_block_to_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DT_SEND && run && blocked) |=> hold);
    p_clear_to_send_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DT_HOLD && run && !blocked) |=> state == DT_SEND);
    p_run_low_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!step && !hold));
endmodule

// File: rtl/page_xfer_ctrl.sv
module page_xfer_ctrl #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 16,
    parameter int PAGE_WORDS = 8,
    parameter int START_DLY  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              rd_loop_en,
    input  logic              rd_page_avail,
    output logic              rd_page_done,
    output logic              rda_req,
    input  logic              rda_ack,
    output logic [ADDR_W-1:0] rda_addr,
    input  logic [DATA_W-1:0] rda_data,
    input  logic              fin_full,
    output logic              fin_push,
    output logic [DATA_W-1:0] fin_data,
    input  logic              run,
    input  logic              fin_empty,
    input  logic              fout_full,
    output logic              dut_step,
    output logic              dut_hold,
    input  logic              wr_start,
    input  logic              wr_page_avail,
    output logic              wr_page_done,
    input  logic              fout_empty,
    input  logic [DATA_W-1:0] fout_data,
    output logic              fout_pop,
    output logic              wbb_req,
    input  logic              wbb_ack,
    output logic [ADDR_W-1:0] wbb_addr,
    output logic [DATA_W-1:0] wbb_data
);
    page_rd_fsm #(
        .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS), .START_DLY(START_DLY)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .start(rd_start), .loop_en(rd_loop_en),
        .page_avail(rd_page_avail), .ack(rda_ack), .fifo_full(fin_full),
        .req(rda_req), .addr(rda_addr), .done(rd_page_done)
    );

    page_wr_fsm #(
        .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS), .START_DLY(START_DLY)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .start(wr_start), .page_avail(wr_page_avail),
        .ack(wbb_ack), .fifo_empty(fout_empty),
        .req(wbb_req), .addr(wbb_addr), .done(wr_page_done)
    );

    page_dut_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .in_empty(fin_empty),
        .out_full(fout_full), .step(dut_step), .hold(dut_hold)
    );

    assign fin_push = rda_req && rda_ack;
    assign fin_data = rda_data;
    assign fout_pop = wbb_req && wbb_ack;
    assign wbb_data = fout_data;

    p_push_only_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fin_push |-> !fin_full);
    p_pop_only_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fout_pop |-> !fout_empty);
endmodule

// File: tb/page_xfer_ctrl_bench.sv
module page_xfer_ctrl_bench;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 16;
    localparam int PAGE_WORDS = 8;
    localparam int START_DLY  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_start = 0, rd_loop_en = 0, rd_page_avail = 0;
    logic rd_page_done, rda_req, fin_push, dut_step, dut_hold;
    logic rda_ack = 0, fin_full = 0, run = 0, fin_empty = 0, fout_full = 0;
    logic wr_start = 0, wr_page_avail = 0, fout_empty = 0, wbb_ack = 0;
    logic wr_page_done, fout_pop, wbb_req;
    logic [ADDR_W-1:0] rda_addr, wbb_addr;
    logic [DATA_W-1:0] rda_data, fin_data, fout_data, wbb_data;
    logic [15:0] pop_cnt;

    int checks = 0;
    int errors = 0;
    int rd_done_cnt = 0;
    int wr_done_cnt = 0;
    bit full_en = 0, empty_en = 0;
    logic prev_rd_done = 0, prev_wr_done = 0;
    logic [47:0] rq[$];
    logic [47:0] wq[$];

    always #4 clk = ~clk;

    assign rda_data  = {16'hA5A5, rda_addr};
    assign fout_data = {16'h5A5A, pop_cnt};

    page_xfer_ctrl #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS), .START_DLY(START_DLY)
    ) u_page_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_loop_en(rd_loop_en),
        .rd_page_avail(rd_page_avail), .rd_page_done(rd_page_done),
        .rda_req(rda_req), .rda_ack(rda_ack), .rda_addr(rda_addr), .rda_data(rda_data),
        .fin_full(fin_full), .fin_push(fin_push), .fin_data(fin_data),
        .run(run), .fin_empty(fin_empty), .fout_full(fout_full),
        .dut_step(dut_step), .dut_hold(dut_hold),
        .wr_start(wr_start), .wr_page_avail(wr_page_avail), .wr_page_done(wr_page_done),
        .fout_empty(fout_empty), .fout_data(fout_data), .fout_pop(fout_pop),
        .wbb_req(wbb_req), .wbb_ack(wbb_ack), .wbb_addr(wbb_addr), .wbb_data(wbb_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic expect_rd_page();
        for (int i = 0; i < PAGE_WORDS; i++)
            rq.push_back({ADDR_W'(i), 16'hA5A5, 16'(i)});
    endtask

    task automatic expect_wr_page(input int base);
        for (int i = 0; i < PAGE_WORDS; i++)
            wq.push_back({ADDR_W'(i), 16'h5A5A, 16'(base + i)});
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    always @(posedge clk or negedge rst_n)
        if (!rst_n) pop_cnt <= '0;
        else if (fout_pop) pop_cnt <= pop_cnt + 16'd1;

    // stall pattern driver for acknowledges and FIFO flags
    initial begin
        int k = 0;
        forever begin
            @(posedge clk); #1;
            k++;
            rda_ack    = (k % 3) != 0;
            fin_full   = full_en && ((k % 5) == 0);
            wbb_ack    = (k % 4) != 1;
            fout_empty = empty_en && ((k % 7) == 3);
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rda_req && fin_full) chk(0, "R4 req while full", 1, 0);
            if (fin_push !== (rda_req && rda_ack)) chk(0, "R3 push", fin_push, rda_req && rda_ack);
            if (rda_req && rda_ack) begin
                if (rq.size() == 0) chk(0, "R3 unexpected read word", rda_addr, 0);
                else begin
                    logic [47:0] e;
                    e = rq.pop_front();
                    chk({rda_addr, fin_data} == e, "R3 read word", {rda_addr, fin_data}, e);
                end
            end
            if (wbb_req && fout_empty) chk(0, "R7 req while empty", 1, 0);
            if (fout_pop !== (wbb_req && wbb_ack)) chk(0, "R7 pop", fout_pop, wbb_req && wbb_ack);
            if (wbb_req && wbb_ack) begin
                if (wq.size() == 0) chk(0, "R7 unexpected write word", wbb_addr, 0);
                else begin
                    logic [47:0] e;
                    e = wq.pop_front();
                    chk({wbb_addr, wbb_data} == e, "R7 write word", {wbb_addr, wbb_data}, e);
                end
            end
            if (rd_page_done) begin
                rd_done_cnt++;
                if (prev_rd_done) chk(0, "R5 done wider than one cycle", 2, 1);
            end
            if (wr_page_done) begin
                wr_done_cnt++;
                if (prev_wr_done) chk(0, "R8 done wider than one cycle", 2, 1);
            end
            prev_rd_done = rd_page_done;
            prev_wr_done = wr_page_done;
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({rda_req, wbb_req, fin_push, fout_pop, dut_step, dut_hold, rd_page_done, wr_page_done} == 8'h00,
            "R11 reset outputs",
            {rda_req, wbb_req, fin_push, fout_pop, dut_step, dut_hold, rd_page_done, wr_page_done}, 0);

        // ---------------- read path ----------------
        expect_rd_page();
        expect_rd_page();
        rd_loop_en = 1;
        tick();
        rd_start = 1;
        tick();
        rd_start = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(rda_req == 0, "R1 no request before page available", rda_req, 0);
        end
        tick();
        rd_page_avail = 1;
        @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rda_req && n < 50);
        chk(n == START_DLY + 3, "R2 read start latency", n, START_DLY + 3);
        full_en = 1;
        while (rd_done_cnt == 0) @(negedge clk);
        tick();
        rd_loop_en = 0;
        while (rd_done_cnt < 2) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(rda_req == 0, "R6 idle after what-next without loop", rda_req, 0);
        end
        chk(rq.size() == 0, "R3 R6 all looped read words seen", rq.size(), 0);
        chk(rd_done_cnt == 2, "R5 one done pulse per page", rd_done_cnt, 2);
        full_en = 0;
        rd_page_avail = 0;

        // ---------------- write path ----------------
        expect_wr_page(0);
        tick();
        wr_start = 1;
        tick();
        wr_start = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(wbb_req == 0, "R7 no write before page available", wbb_req, 0);
        end
        tick();
        wr_page_avail = 1;
        @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!wbb_req && n < 50);
        chk(n == START_DLY + 3, "R7 write start latency", n, START_DLY + 3);
        empty_en = 1;
        while (wr_done_cnt == 0) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(wbb_req == 0, "R8 write idle after finish", wbb_req, 0);
        end
        chk(wq.size() == 0, "R7 all write words seen", wq.size(), 0);
        chk(wr_done_cnt == 1, "R8 one write done pulse", wr_done_cnt, 1);
        empty_en = 0;
        wr_page_avail = 0;

        // ---------------- DUT stream ----------------
        tick();
        chk(dut_step == 0 && dut_hold == 0, "R10 idle while run low", {dut_step, dut_hold}, 0);
        run = 1; fin_empty = 0; fout_full = 0;
        repeat (2) tick();
        @(negedge clk);
        chk(dut_step == 1 && dut_hold == 0, "R9 sending when clear", {dut_step, dut_hold}, 2'b10);
        tick();
        fin_empty = 1;
        @(negedge clk);
        chk(dut_step == 0, "R9 no step on empty input", dut_step, 0);
        tick();
        @(negedge clk);
        chk(dut_step == 0 && dut_hold == 1, "R9 hold on empty input", {dut_step, dut_hold}, 2'b01);
        tick();
        fin_empty = 0;
        tick();
        @(negedge clk);
        chk(dut_step == 1 && dut_hold == 0, "R9 resume after clear", {dut_step, dut_hold}, 2'b10);
        tick();
        fout_full = 1;
        tick();
        @(negedge clk);
        chk(dut_step == 0 && dut_hold == 1, "R9 hold on full output", {dut_step, dut_hold}, 2'b01);
        tick();
        run = 0;
        fout_full = 0;
        tick();
        @(negedge clk);
        chk(dut_step == 0 && dut_hold == 0, "R10 idle after run low", {dut_step, dut_hold}, 0);
        repeat (3) tick();
        @(negedge clk);
        chk(dut_step == 0 && dut_hold == 0, "R10 stays idle with clear FIFOs", {dut_step, dut_hold}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule